// File: doc/BRIEF.md
# Incremental Pulse Program-Verify Controller

This block drives the programming of one wordline in a multi-level cell array. A program operation alternates a pulse slot and one or two verify slots. In the pulse slot it raises a pulse strobe together with a program-voltage step code. The code starts at its lowest step for each operation and climbs by one step after every pulse until it reaches its top step. In the verify slots, which only occur while no pulse is active, it raises a verify strobe with a reference select. It then reads back one pass flag per bitline. A bitline whose cell has reached the reference it is aiming for is inhibited from the next cycle on and stays inhibited until the operation ends. Bitlines that are meant to stay erased are inhibited from the first pulse.

Each bitline carries a two-bit target level. Programming is split into two ordered operations. The upper operation lifts every cell whose target is the middle or top level to the middle reference. The lower operation then lifts erased cells with target level 1 to the lowest reference, and lifts cells with target level 3 from the middle reference to the top reference. A lower request is accepted only when an upper operation has completed successfully since the last lower operation; otherwise it is rejected. An operation completes when every bitline is inhibited. It fails if the pulse budget latched at start runs out before that happens.

Top module: `pgm_verify_ctrl`

## Requirements
- R1: After reset, busy, done, fail, rejected, pulse_stb and vfy_stb are low, vpgm_code is 0 and inh_mask is all ones.
- R2: A start accepted while idle raises busy in the next cycle and loads inh_mask from tgt_lvl (bitline i uses bits [2i+1:2i]; code 0 is erased, 1, 2 and 3 are the lowest, middle and top levels). For an upper operation (page_lower=0), bitlines with code 0 or 1 are inhibited. For a lower operation (page_lower=1), bitlines with code 0 or 2 are inhibited.
- R3: pulse_stb and vfy_stb are never high in the same cycle. In an upper operation each pulse is followed by one verify cycle with vfy_ref=2. In a lower operation each pulse is followed by a verify cycle with vfy_ref=1 and then one with vfy_ref=3. vfy_ref is 0 when no verify is active.
- R4: During a verify cycle, a bitline whose sense_pass bit is high is inhibited from the next cycle on only if vfy_ref equals its aim. The aim is 2 in an upper operation and the bitline's target code in a lower operation. A pass at any other reference has no effect. An inhibited bitline stays inhibited for the rest of the operation.
- R5: vpgm_code is 0 in the first pulse of each operation. It rises by one after the last verify cycle of every pulse and holds at 2^VW-1 rather than wrapping.
- R6: In a pulse slot where every bitline is already inhibited, no pulse is issued and done is high for exactly the next cycle, with busy low. This takes priority over the pulse budget.
- R7: In a pulse slot where the number of pulses already issued equals the max_pulses value latched at start, and some bitline is still uninhibited, no pulse is issued and fail is high for exactly the next cycle, with busy low. A budget of 0 fails without any pulse.
- R8: A lower start is rejected unless an upper operation has ended with done since reset or since the last lower operation. Rejection raises rejected for one cycle and leaves busy low and inh_mask unchanged.
- R9: A start that arrives while busy is ignored: the running operation continues and rejected stays low.
- R10: After an upper operation and then a lower operation, both completing with done, every cell sits at the level its target code names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request, sampled while idle |
| page_lower | input | 1 | 0 selects the upper operation, 1 the lower operation |
| tgt_lvl | input | 2*NBL | Two-bit target level code per bitline |
| max_pulses | input | CW | Pulse budget, latched at start |
| sense_pass | input | NBL | Per-bitline verify result for the current vfy_ref |
| vpgm_code | output | VW | Program-voltage step code |
| inh_mask | output | NBL | Per-bitline inhibit, 1 means inhibited |
| pulse_stb | output | 1 | Program pulse active |
| vfy_stb | output | 1 | Verify read active |
| vfy_ref | output | 2 | Reference select for the verify read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion flag |
| fail | output | 1 | One-cycle pulse-budget failure flag |
| rejected | output | 1 | One-cycle flag for a refused lower request |

## Verification
Completion and budget exhaustion can both be true in the same pulse slot: the last bitline is inhibited by the verify that follows the final pulse the budget allows. To provoke this, the bench runs with fixed one-unit threshold steps, so it is known that the cells need exactly 20 pulses, and then sets the budget to exactly 20 pulses. The run must end with done and without fail. The same stimulus with a budget of 19 must end with fail after 19 pulses.

// File: rtl/pv_pkg.sv
package pv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_VLO   = 2'd2,
    ST_VHI   = 2'd3
  } pv_state_e;

  localparam logic [1:0] REF_NONE = 2'd0;
  localparam logic [1:0] REF_LO   = 2'd1;
  localparam logic [1:0] REF_MID  = 2'd2;
  localparam logic [1:0] REF_HI   = 2'd3;

  localparam logic [1:0] LV_ERASED = 2'd0;
  localparam logic [1:0] LV_LO     = 2'd1;
  localparam logic [1:0] LV_MID    = 2'd2;

  // lane needs no charge in this operation
  function automatic logic lane_idle(input logic lower, input logic [1:0] lvl);
    if (lower) return (lvl == LV_ERASED) || (lvl == LV_MID);
    else       return (lvl == LV_ERASED) || (lvl == LV_LO);
  endfunction

  // reference a lane must reach in this operation
  function automatic logic [1:0] lane_aim(input logic lower, input logic [1:0] lvl);
    if (lower) return lvl;
    else       return REF_MID;
  endfunction

endpackage

// File: rtl/pv_seq.sv
module pv_seq
  import pv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       page_lower,
  input  logic       all_inh,
  input  logic       cnt_at_max,
  output logic       ld,
  output logic       pulse_fire,
  output logic       vfy_fire,
  output logic [1:0] vfy_sel,
  output logic       step,
  output logic       page_q,
  output logic       busy,
  output logic       done_q,
  output logic       fail_q,
  output logic       rej_q
);

  pv_state_e state_q, state_d;
  logic      page_d;
  logic      uok_q, uok_d;
  logic      done_d, fail_d, rej_d;

  always_comb begin
    state_d    = state_q;
    page_d     = page_q;
    uok_d      = uok_q;
    done_d     = 1'b0;
    fail_d     = 1'b0;
    rej_d      = 1'b0;
    ld         = 1'b0;
    pulse_fire = 1'b0;
    vfy_fire   = 1'b0;
    vfy_sel    = REF_NONE;
    step       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (page_lower && !uok_q) begin
            rej_d = 1'b1;
          end else begin
            ld      = 1'b1;
            page_d  = page_lower;
            state_d = ST_PULSE;
            if (!page_lower) uok_d = 1'b0;
          end
        end
      end
      ST_PULSE: begin
        if (all_inh) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
          uok_d   = !page_q;
        end else if (cnt_at_max) begin
          fail_d  = 1'b1;
          state_d = ST_IDLE;
          if (page_q) uok_d = 1'b0;
        end else begin
          pulse_fire = 1'b1;
          state_d    = ST_VLO;
        end
      end
      ST_VLO: begin
        vfy_fire = 1'b1;
        if (page_q) begin
          vfy_sel = REF_LO;
          state_d = ST_VHI;
        end else begin
          vfy_sel = REF_MID;
          step    = 1'b1;
          state_d = ST_PULSE;
        end
      end
      ST_VHI: begin
        vfy_fire = 1'b1;
        vfy_sel  = REF_HI;
        step     = 1'b1;
        state_d  = ST_PULSE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= 1'b0;
      uok_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      uok_q   <= uok_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      rej_q   <= rej_d;
    end
  end

endmodule

// File: rtl/pv_vstep.sv
module pv_vstep #(
  parameter int VW = 4,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          step,
  input  logic          pulse_fire,
  input  logic [CW-1:0] max_pulses,
  output logic [VW-1:0] vcode,
  output logic          at_max
);

  localparam logic [VW-1:0] VTOP = {VW{1'b1}};

  logic [VW-1:0] vcode_q, vcode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q;
  logic          v_en, c_en;

  always_comb begin
    v_en    = ld || (step && (vcode_q != VTOP));
    vcode_d = ld ? '0 : vcode_q + 1'b1;
    c_en    = ld || pulse_fire;
    cnt_d   = ld ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcode_q <= '0;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else begin
      if (v_en) vcode_q <= vcode_d;
      if (c_en) cnt_q   <= cnt_d;
      if (ld)   lim_q   <= max_pulses;
    end
  end

  assign vcode  = vcode_q;
  assign at_max = (cnt_q == lim_q);

endmodule

// File: rtl/pv_inhibit.sv
module pv_inhibit
  import pv_pkg::*;
#(
  parameter int NBL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             ld_page,
  input  logic [2*NBL-1:0] tgt,
  input  logic             page_q,
  input  logic             vfy_fire,
  input  logic [1:0]       vfy_sel,
  input  logic [NBL-1:0]   sense,
  output logic [NBL-1:0]   inh,
  output logic             all_inh
);

  for (genvar g = 0; g < NBL; g++) begin : g_lane
    logic [1:0] aim_lvl_q;
    logic       inh_q, inh_d, inh_en;
    logic       hit;

    always_comb begin
      hit    = vfy_fire && sense[g] && (vfy_sel == lane_aim(page_q, aim_lvl_q));
      inh_en = ld || hit;
      inh_d  = ld ? lane_idle(ld_page, tgt[2*g +: 2]) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        aim_lvl_q <= LV_ERASED;
        inh_q     <= 1'b1;
      end else begin
        if (ld)     aim_lvl_q <= tgt[2*g +: 2];
        if (inh_en) inh_q     <= inh_d;
      end
    end

    assign inh[g] = inh_q;
  end

  assign all_inh = &inh;

endmodule

// File: rtl/pgm_verify_ctrl.sv
module pgm_verify_ctrl #(
  parameter int NBL = 8,
  parameter int VW  = 4,
  parameter int CW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             page_lower,
  input  logic [2*NBL-1:0] tgt_lvl,
  input  logic [CW-1:0]    max_pulses,
  input  logic [NBL-1:0]   sense_pass,
  output logic [VW-1:0]    vpgm_code,
  output logic [NBL-1:0]   inh_mask,
  output logic             pulse_stb,
  output logic             vfy_stb,
  output logic [1:0]       vfy_ref,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             rejected
);

  logic ld, step, page_q, all_inh, cnt_at_max;

  pv_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .page_lower (page_lower),
    .all_inh    (all_inh),
    .cnt_at_max (cnt_at_max),
    .ld         (ld),
    .pulse_fire (pulse_stb),
    .vfy_fire   (vfy_stb),
    .vfy_sel    (vfy_ref),
    .step       (step),
    .page_q     (page_q),
    .busy       (busy),
    .done_q     (done),
    .fail_q     (fail),
    .rej_q      (rejected)
  );

  pv_vstep #(.VW(VW), .CW(CW)) u_vstep (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld         (ld),
    .step       (step),
    .pulse_fire (pulse_stb),
    .max_pulses (max_pulses),
    .vcode      (vpgm_code),
    .at_max     (cnt_at_max)
  );

  pv_inhibit #(.NBL(NBL)) u_inh (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (ld),
    .ld_page  (page_lower),
    .tgt      (tgt_lvl),
    .page_q   (page_q),
    .vfy_fire (vfy_stb),
    .vfy_sel  (vfy_ref),
    .sense    (sense_pass),
    .inh      (inh_mask),
    .all_inh  (all_inh)
  );

endmodule

// File: rtl/pgm_verify_ctrl_chk.sv
module pgm_verify_ctrl_chk #(
  parameter int NBL = 8,
  parameter int VW  = 4,
  parameter int CW  = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [VW-1:0]  vpgm_code,
  input logic [NBL-1:0] inh_mask,
  input logic           pulse_stb,
  input logic           vfy_stb,
  input logic [1:0]     vfy_ref,
  input logic           busy,
  input logic           done,
  input logic           fail,
  input logic           rejected
);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulse_stb && vfy_stb));

  // R3
  vfy_ref_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_stb |-> (vfy_ref != 2'd0));

  // R4
  inh_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((inh_mask & $past(inh_mask)) == $past(inh_mask)));

  // R5
  vcode_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (vpgm_code >= $past(vpgm_code)));

  // R6
  pulse_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_stb |-> (inh_mask != {NBL{1'b1}}));

  // R6
  done_after_all_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(&inh_mask));

  // R7
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R8
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> !busy);

endmodule

bind pgm_verify_ctrl pgm_verify_ctrl_chk #(.NBL(NBL), .VW(VW), .CW(CW)) u_chk (.*);

// File: tb/sim_pgm_verify_ctrl.sv
`timescale 1ns/1ps
module sim_pgm_verify_ctrl;
  localparam int NBL = 8;
  localparam int VW  = 4;
  localparam int CW  = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic             page_lower;
  logic [2*NBL-1:0] tgt_lvl;
  logic [CW-1:0]    max_pulses;
  logic [NBL-1:0]   sense_pass;
  logic [VW-1:0]    vpgm_code;
  logic [NBL-1:0]   inh_mask;
  logic             pulse_stb, vfy_stb, busy, done, fail, rejected;
  logic [1:0]       vfy_ref;

  int  total = 0;
  int  bad   = 0;
  bit  run   = 0;
  bit  slow  = 0;
  bit  finished = 0;
  int  vth [NBL];

  always #4 clk = ~clk;

  pgm_verify_ctrl #(.NBL(NBL), .VW(VW), .CW(CW)) u0 (.*);

  function automatic int refv(input logic [1:0] r);
    case (r)
      2'd1: return 10;
      2'd2: return 20;
      2'd3: return 30;
      default: return 100000;
    endcase
  endfunction

  function automatic int lvl_of(input int v);
    if (v >= 30) return 3;
    if (v >= 20) return 2;
    if (v >= 10) return 1;
    return 0;
  endfunction

  // behavioural cell array: threshold read against the selected reference
  always_comb begin
    for (int i = 0; i < NBL; i++) sense_pass[i] = (vth[i] >= refv(vfy_ref));
  end

  // each pulse adds charge to cells that are not inhibited
  always @(negedge clk) begin
    if (pulse_stb) begin
      for (int i = 0; i < NBL; i++) begin
        if (!inh_mask[i]) begin
          if (slow) vth[i] += 1;
          else      vth[i] += 1 + $urandom_range(0, (int'(vpgm_code) / 5));
        end
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int         m_st;
  bit         m_page, m_uok;
  bit [1:0]   m_tgt [NBL];
  bit [NBL-1:0] m_inh;
  int         m_v, m_cnt, m_max;
  bit         e_done, e_fail, e_rej;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_page = 0; m_uok = 0; m_inh = '1;
      m_v = 0; m_cnt = 0; m_max = 0;
      e_done = 0; e_fail = 0; e_rej = 0;
      for (int i = 0; i < NBL; i++) m_tgt[i] = 0;
    end else begin
      e_done = 0; e_fail = 0; e_rej = 0;
      case (m_st)
        0: if (start) begin
          if (page_lower && !m_uok) e_rej = 1;
          else begin
            m_page = page_lower;
            if (!page_lower) m_uok = 0;
            for (int i = 0; i < NBL; i++) begin
              m_tgt[i] = tgt_lvl[2*i +: 2];
              if (page_lower) m_inh[i] = (m_tgt[i] == 0) || (m_tgt[i] == 2);
              else            m_inh[i] = (m_tgt[i] < 2);
            end
            m_v = 0; m_cnt = 0; m_max = int'(max_pulses);
            m_st = 1;
          end
        end
        1: begin
          if (&m_inh) begin
            e_done = 1; m_st = 0; m_uok = !m_page;
          end else if (m_cnt == m_max) begin
            e_fail = 1; m_st = 0;
            if (m_page) m_uok = 0;
          end else begin
            m_cnt++; m_st = 2;
          end
        end
        2, 3: begin
          int r;
          r = (m_st == 3) ? 3 : (m_page ? 1 : 2);
          for (int i = 0; i < NBL; i++) begin
            int aim;
            aim = m_page ? int'(m_tgt[i]) : 2;
            if (vth[i] >= refv(r[1:0]) && aim == r) m_inh[i] = 1;
          end
          if (m_st == 2 && m_page) m_st = 3;
          else begin
            if (m_v < 15) m_v++;
            m_st = 1;
          end
        end
        default: m_st = 0;
      endcase
    end
  end

  // cycle compare, away from the active edge
  always @(negedge clk) begin
    if (run) begin
      bit ep;
      int er;
      ep = (m_st == 1) && !(&m_inh) && (m_cnt != m_max);
      er = (m_st == 2) ? (m_page ? 1 : 2) : ((m_st == 3) ? 3 : 0);
      chk("R2 busy",        busy, m_st != 0);
      chk("R4 inh_mask",    inh_mask, m_inh);
      chk("R3 pulse_stb",   pulse_stb, ep);
      chk("R3 vfy_stb",     vfy_stb, (m_st == 2) || (m_st == 3));
      chk("R3 vfy_ref",     vfy_ref, er);
      chk("R5 vpgm_code",   vpgm_code, m_v);
      chk("R6 done",        done, e_done);
      chk("R7 fail",        fail, e_fail);
      chk("R8 rejected",    rejected, e_rej);
    end
  end

  // ---------------- stimulus ----------------
  task automatic erase_cells();
    for (int i = 0; i < NBL; i++) vth[i] = 0;
  endtask

  task automatic try_reject();
    @(negedge clk);
    start = 1; page_lower = 1;
    @(negedge clk);
    start = 0;
    chk("R8 lower refused", rejected, 1);
    chk("R8 stays idle", busy, 0);
  endtask

  task automatic run_op(input bit lower, input logic [2*NBL-1:0] tg, input int maxp,
                        input bit poke, output bit od, output bit of,
                        output int npulse, output int peakv);
    logic [NBL-1:0] emask;
    int cyc;
    for (int i = 0; i < NBL; i++) begin
      if (lower) emask[i] = (tg[2*i +: 2] == 2'd0) || (tg[2*i +: 2] == 2'd2);
      else       emask[i] = (tg[2*i +: 2] < 2'd2);
    end
    @(negedge clk);
    start = 1; page_lower = lower; tgt_lvl = tg; max_pulses = maxp[CW-1:0];
    @(negedge clk);
    start = 0;
    chk("R2 busy after start", busy, 1);
    chk("R2 loaded mask", inh_mask, emask);
    npulse = 0; peakv = 0; cyc = 0;
    while (!(done || fail) && cyc < 2000) begin
      if (pulse_stb) npulse++;
      if (int'(vpgm_code) > peakv) peakv = int'(vpgm_code);
      if (poke && cyc == 3) begin
        start = 1; page_lower = 1;
      end else begin
        start = 0;
      end
      @(negedge clk);
      if (poke && cyc == 3) begin
        chk("R9 start ignored busy", busy, 1);
        chk("R9 start ignored rej", rejected, 0);
      end
      cyc++;
    end
    start = 0;
    od = done; of = fail;
  endtask

  task automatic chk_levels(input logic [2*NBL-1:0] tg);
    for (int i = 0; i < NBL; i++)
      chk("R10 final level", lvl_of(vth[i]), tg[2*i +: 2]);
  endtask

  initial begin
    bit od, of;
    int np, pv;
    logic [2*NBL-1:0] ta, tr;
    rst_n = 0; start = 0; page_lower = 0; tgt_lvl = '0; max_pulses = '0;
    erase_cells();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    chk("R1 rejected", rejected, 0);
    chk("R1 pulse_stb", pulse_stb, 0);
    chk("R1 vfy_stb", vfy_stb, 0);
    chk("R1 vpgm_code", vpgm_code, 0);
    chk("R1 inh_mask", inh_mask, {NBL{1'b1}});
    run = 1;

    try_reject();

    ta = {2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0};
    run_op(0, ta, 63, 1, od, of, np, pv);
    chk("R6 upper done", od, 1);
    run_op(1, ta, 63, 0, od, of, np, pv);
    chk("R6 lower done", od, 1);
    chk_levels(ta);
    try_reject();

    erase_cells();
    run_op(0, {NBL{2'd3}}, 2, 0, od, of, np, pv);
    chk("R7 budget fail", of, 1);
    chk("R7 pulses used", np, 2);
    try_reject();

    run_op(0, '0, 5, 0, od, of, np, pv);
    chk("R6 nothing to do", od, 1);
    chk("R6 no pulses", np, 0);

    erase_cells();
    slow = 1;
    run_op(0, {NBL{2'd2}}, 20, 0, od, of, np, pv);
    chk("R6 done wins over budget", od, 1);
    chk("R6 not failed", of, 0);
    chk("R6 pulse count", np, 20);
    chk("R5 saturated code", pv, 15);

    erase_cells();
    run_op(0, {NBL{2'd2}}, 19, 0, od, of, np, pv);
    chk("R7 short budget", of, 1);
    chk("R7 short pulses", np, 19);

    run_op(0, {NBL{2'd2}}, 0, 0, od, of, np, pv);
    chk("R7 zero budget", of, 1);
    chk("R7 zero pulses", np, 0);
    slow = 0;

    for (int w = 0; w < 4; w++) begin
      erase_cells();
      tr = 16'($urandom);
      run_op(0, tr, 63, 0, od, of, np, pv);
      chk("R6 random upper", od, 1);
      run_op(1, tr, 63, 0, od, of, np, pv);
      chk("R6 random lower", od, 1);
      chk_levels(tr);
    end

    repeat (4) @(negedge clk);
    run = 0;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule